// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the engine of one DMA channel. A peripheral pulses a request line, and the channel answers by moving data across a shared memory port. Each move is a read beat at the source pointer followed by a write beat of the same data at the destination pointer. Each pointer steps on its own: it can stay fixed, count up or count down, by 1, 2, 4 or 8 bytes. Two down-counters track the bytes left in the current buffer and in the current block. The trigger mode sets how much work one request starts: a single buffer, a whole block, or a whole block after which both pointers return to their start addresses. A fourth mode behaves like block mode and also flags the block boundary, for an outer list walker.

Some peripherals have no hardware acknowledge line. For these, the channel can finish each unit of work by writing a programmed value to a programmed address. Requests that arrive while the channel is busy collapse into one pending bit. The channel checks the configuration when a unit starts and again before every beat. On a bad value it raises an error pulse and issues no beat.

Top module: `dma_chan_seq`

## Requirements
- R1: Pointer mode codes, per side: 2'b00 holds the pointer, 2'b10 adds the step after each write beat, 2'b11 subtracts it, and 2'b01 acts as 2'b00.
- R2: A step size code k (0..3) means 2^k bytes. Each beat moves 2^k bytes of the source code and drives mem_size = cfg_src_size. The destination pointer moves by 2^k bytes of its own code.
- R3: A beat is a read (mem_we=0) at the source pointer, then a write (mem_we=1) of the data that was read to the destination pointer. While a request waits for mem_gnt, it stays asserted with the same address.
- R4: Trigger code 2'b00 (buffer): one request moves cfg_buf_len bytes, or what is left of the block if that is less. The byte counts and pointers carry over from one request to the next.
- R5: Trigger code 2'b01 (block): one request runs until the block count reaches zero. buf_done pulses at every buffer boundary. blk_done pulses at the block end, together with buf_done.
- R6: Trigger code 2'b10 (repeated block): behaves as block mode, and at every block end both pointers reload their base addresses.
- R7: Trigger code 2'b11 (list): behaves as block mode, and lst_end pulses in the same cycle as blk_done.
- R8: If cfg_buf_len is 0 or above 128, or cfg_blk_len is 0 or above 65536, a request produces one cfg_err pulse and no beat.
- R9: If the step is larger than the bytes left in the buffer or block, the channel pulses cfg_err, issues no beat and abandons the unit. The next request restarts from the base addresses and the full counts.
- R10: With cfg_ack_en=1, a unit that completes ends with one write of cfg_ack_data (zero-extended) to cfg_ack_addr, with mem_size = 2.
- R11: Any number of requests that arrive while a unit is in flight start exactly one further unit.
- R12: mem_prio equals cfg_prio on every beat.
- R13: After reset, and while ch_en=0, the channel issues no beat, busy is low and requests are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable; low clears all progress |
| cfg_src_mode | input | 2 | Source pointer mode |
| cfg_dst_mode | input | 2 | Destination pointer mode |
| cfg_src_size | input | 2 | Source step / beat size code |
| cfg_dst_size | input | 2 | Destination step size code |
| cfg_buf_len | input | BUF_W | Buffer length in bytes |
| cfg_blk_len | input | BLK_W | Block length in bytes |
| cfg_trig | input | 2 | Trigger mode |
| cfg_prio | input | 2 | Priority level, 0 low to 3 very high |
| cfg_src_base | input | AW | Source start address |
| cfg_dst_base | input | AW | Destination start address |
| cfg_ack_en | input | 1 | Enable the acknowledge write |
| cfg_ack_addr | input | AW | Acknowledge write address |
| cfg_ack_data | input | 32 | Acknowledge write value |
| periph_req | input | 1 | Peripheral request pulse |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | AW | Beat address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | DW | Write data |
| mem_prio | output | 2 | Beat priority |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_rdata | input | DW | Read data, valid with the read grant |
| busy | output | 1 | Unit in flight or pending |
| buf_done | output | 1 | Buffer end pulse |
| blk_done | output | 1 | Block end pulse |
| lst_end | output | 1 | Block end pulse in list mode |
| cfg_err | output | 1 | Configuration error pulse |

## Verification
The bench targets the places where the two counters interact. One case is a buffer mode run whose last request ends short because the block count runs out first. A design that looked only at the buffer count would overrun the block or miss the block-done pulse. Another case ends mid-buffer on a count smaller than the step. A design that split the beat, or resumed from the old pointers on the next request, would produce extra writes at the wrong addresses. Further cases cover a decrementing destination that steps by a different size than the source, pointer reload in repeated mode, bursts of requests that must merge into one extra unit, and random grant stalls that must not change the beat sequence.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    PM_HOLD = 2'b00,
    PM_ALSO_HOLD = 2'b01,
    PM_UP = 2'b10,
    PM_DOWN = 2'b11
  } ptr_mode_e;

  typedef enum logic [1:0] {
    TM_BUFFER = 2'b00,
    TM_BLOCK = 2'b01,
    TM_REPEAT = 2'b10,
    TM_LIST = 2'b11
  } trig_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD,
    ST_WR,
    ST_ACK
  } seq_state_e;

  // Size code to byte count: 0..3 -> 1, 2, 4, 8
  function automatic logic [3:0] step_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] ptr
);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p,
                                             input logic [1:0] m,
                                             input logic [1:0] s);
    logic [AW-1:0] st;
    st = AW'(step_bytes(s));
    case (m)
      PM_UP:   return p + st;
      PM_DOWN: return p - st;
      default: return p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= base;
    else if (adv)  ptr <= next_ptr(ptr, mode, size);
  end

  AST_HOLD_MODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && (mode == PM_HOLD || mode == PM_ALSO_HOLD) |=> $stable(ptr)); // R1

endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
  parameter int BUF_W = 8,
  parameter int BLK_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [3:0]       amt,
  input  logic [BUF_W-1:0] buf_len,
  input  logic [BLK_W-1:0] blk_len,
  output logic [BUF_W-1:0] buf_rem,
  output logic [BLK_W-1:0] blk_rem,
  output logic             buf_end,
  output logic             blk_end
);

  logic [BUF_W-1:0] buf_nxt;
  logic [BLK_W-1:0] blk_nxt;

  always_comb begin
    buf_nxt = buf_rem - BUF_W'(amt);
    blk_nxt = blk_rem - BLK_W'(amt);
    blk_end = dec && (blk_nxt == '0);
    buf_end = dec && ((buf_nxt == '0) || (blk_nxt == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_rem <= '0;
      blk_rem <= '0;
    end else if (load) begin
      buf_rem <= buf_len;
      blk_rem <= blk_len;
    end else if (dec) begin
      if (blk_end) begin
        buf_rem <= buf_len;
        blk_rem <= blk_len;
      end else if (buf_end) begin
        buf_rem <= buf_len;
        blk_rem <= blk_nxt;
      end else begin
        buf_rem <= buf_nxt;
        blk_rem <= blk_nxt;
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (BLK_W'(amt) <= blk_rem) && (BUF_W'(amt) <= buf_rem)); // R9

  AST_BLOCK_END_MARKS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> buf_end); // R5

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int BUF_W = 8,
  parameter int BLK_W = 17,
  parameter int BUF_MAX = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic [1:0]       cfg_src_mode,
  input  logic [1:0]       cfg_dst_mode,
  input  logic [1:0]       cfg_src_size,
  input  logic [1:0]       cfg_dst_size,
  input  logic [BUF_W-1:0] cfg_buf_len,
  input  logic [BLK_W-1:0] cfg_blk_len,
  input  logic [1:0]       cfg_trig,
  input  logic [1:0]       cfg_prio,
  input  logic [AW-1:0]    cfg_src_base,
  input  logic [AW-1:0]    cfg_dst_base,
  input  logic             cfg_ack_en,
  input  logic [AW-1:0]    cfg_ack_addr,
  input  logic [31:0]      cfg_ack_data,
  input  logic             periph_req,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  output logic [DW-1:0]    mem_wdata,
  output logic [1:0]       mem_prio,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             buf_done,
  output logic             blk_done,
  output logic             lst_end,
  output logic             cfg_err
);

  localparam int BLK_MAX = 1 << (BLK_W - 1);

  function automatic logic cfg_valid(input logic [BUF_W-1:0] bl,
                                     input logic [BLK_W-1:0] kl);
    return (bl != '0) && (int'(bl) <= BUF_MAX) &&
           (kl != '0) && (int'(kl) <= BLK_MAX);
  endfunction

  seq_state_e state_q, state_d;
  logic pend_q, loaded_q;
  logic [DW-1:0] data_q;

  logic start_go, start_ok, start_bad, chk_bad;
  logic rd_ack, wr_ack, ack_ack, unit_end;
  logic ctr_load, src_load, dst_load, rpt_reload;
  logic [BUF_W-1:0] buf_rem;
  logic [BLK_W-1:0] blk_rem;
  logic [BLK_W-1:0] chunk, beat;
  logic buf_end, blk_end;
  logic [AW-1:0] src_ptr, dst_ptr;

  // Named events
  assign start_go  = (state_q == ST_IDLE) && pend_q && ch_en;
  assign start_ok  = start_go && cfg_valid(cfg_buf_len, cfg_blk_len);
  assign start_bad = start_go && !cfg_valid(cfg_buf_len, cfg_blk_len);
  assign beat      = BLK_W'(step_bytes(cfg_src_size));
  assign chunk     = (BLK_W'(buf_rem) < blk_rem) ? BLK_W'(buf_rem) : blk_rem;
  assign chk_bad   = ch_en && (state_q == ST_CHK) && (chunk < beat);
  assign rd_ack    = ch_en && (state_q == ST_RD) && mem_gnt;
  assign wr_ack    = ch_en && (state_q == ST_WR) && mem_gnt;
  assign ack_ack   = ch_en && (state_q == ST_ACK) && mem_gnt;
  assign unit_end  = wr_ack && (blk_end || (buf_end && cfg_trig == TM_BUFFER));
  assign ctr_load  = start_ok && !loaded_q;
  assign rpt_reload = blk_end && (cfg_trig == TM_REPEAT);
  assign src_load  = ctr_load || rpt_reload;
  assign dst_load  = ctr_load || rpt_reload;

  dma_len_ctr #(.BUF_W(BUF_W), .BLK_W(BLK_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .dec(wr_ack),
    .amt(step_bytes(cfg_src_size)), .buf_len(cfg_buf_len), .blk_len(cfg_blk_len),
    .buf_rem(buf_rem), .blk_rem(blk_rem), .buf_end(buf_end), .blk_end(blk_end)
  );

  dma_ptr_unit #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(src_load), .adv(wr_ack),
    .base(cfg_src_base), .mode(cfg_src_mode), .size(cfg_src_size), .ptr(src_ptr)
  );

  dma_ptr_unit #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(dst_load), .adv(wr_ack),
    .base(cfg_dst_base), .mode(cfg_dst_mode), .size(cfg_dst_size), .ptr(dst_ptr)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_CHK;
      ST_CHK:  state_d = chk_bad ? ST_IDLE : ST_RD;
      ST_RD:   if (rd_ack) state_d = ST_WR;
      ST_WR: begin
        if (wr_ack) begin
          if (!unit_end)       state_d = ST_CHK;
          else if (cfg_ack_en) state_d = ST_ACK;
          else                 state_d = ST_IDLE;
        end
      end
      ST_ACK:  if (ack_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (!ch_en) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      loaded_q <= 1'b0;
      data_q   <= '0;
    end else begin
      state_q <= state_d;
      if (!ch_en)          pend_q <= 1'b0;
      else if (periph_req) pend_q <= 1'b1;
      else if (start_go)   pend_q <= 1'b0;
      if (!ch_en || chk_bad || start_bad) loaded_q <= 1'b0;
      else if (start_ok)                  loaded_q <= 1'b1;
      if (rd_ack) data_q <= mem_rdata;
    end
  end

  // Memory port
  always_comb begin
    mem_req   = (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_ACK);
    mem_we    = (state_q == ST_WR) || (state_q == ST_ACK);
    mem_addr  = src_ptr;
    mem_size  = cfg_src_size;
    mem_wdata = data_q;
    if (state_q == ST_WR) mem_addr = dst_ptr;
    if (state_q == ST_ACK) begin
      mem_addr  = cfg_ack_addr;
      mem_size  = 2'd2;
      mem_wdata = DW'(cfg_ack_data);
    end
  end

  assign mem_prio = cfg_prio;
  assign busy     = (state_q != ST_IDLE) || pend_q;
  assign buf_done = buf_end;
  assign blk_done = blk_end;
  assign lst_end  = blk_end && (cfg_trig == TM_LIST);
  assign cfg_err  = start_bad || chk_bad;

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && ch_en |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR) && ($past(state_q) != ST_WR) |-> $past(rd_ack)); // R3

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !mem_req); // R8

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !mem_req && !pend_q); // R13

  AST_ACK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ack |=> !mem_req); // R10

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

  localparam logic [31:0] ACK_A = 32'h4000_0010;
  localparam logic [31:0] SRC_B = 32'h0000_1000;
  localparam logic [31:0] DST_B = 32'h0000_2000;
  localparam logic [1:0]  PRIO  = 2'b11;

  typedef struct packed {
    logic [1:0]  sm, dm, ss, ds;
    logic [7:0]  bl;
    logic [16:0] kl;
    logic [1:0]  tm;
    logic        ae;
    logic [3:0]  nr;
    logic [7:0]  ew, eb, ek;
    logic [3:0]  el, ee, ea;
    logic [31:0] ed, es;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 2'b10, 2'd2, 2'd2, 8'd16, 17'd64, 2'd0, 1'b0, 4'd1, 8'd4,  8'd1, 8'd0, 4'd0, 4'd0, 4'd0, 32'h200C, 32'h100C}, // R4 R2
    '{2'b00, 2'b11, 2'd0, 2'd1, 8'd4,  17'd8,  2'd1, 1'b0, 4'd1, 8'd8,  8'd2, 8'd1, 4'd0, 4'd0, 4'd0, 32'h1FF2, 32'h1000}, // R5 R1 R2
    '{2'b10, 2'b10, 2'd3, 2'd3, 8'd16, 17'd32, 2'd2, 1'b0, 4'd2, 8'd8,  8'd4, 8'd2, 4'd0, 4'd0, 4'd0, 32'h2018, 32'h1018}, // R6
    '{2'b10, 2'b10, 2'd0, 2'd0, 8'd8,  17'd20, 2'd0, 1'b0, 4'd3, 8'd20, 8'd3, 8'd1, 4'd0, 4'd0, 4'd0, 32'h2013, 32'h1013}, // R4 short last buffer
    '{2'b10, 2'b00, 2'd2, 2'd2, 8'd8,  17'd8,  2'd1, 1'b1, 4'd1, 8'd2,  8'd1, 8'd1, 4'd0, 4'd0, 4'd1, 32'h2000, 32'h1004}, // R10
    '{2'b10, 2'b10, 2'd2, 2'd2, 8'd6,  17'd6,  2'd0, 1'b0, 4'd2, 8'd2,  8'd0, 8'd0, 4'd0, 4'd2, 4'd0, 32'h2000, 32'h1000}, // R9
    '{2'b10, 2'b10, 2'd0, 2'd0, 8'd4,  17'd0,  2'd1, 1'b0, 4'd1, 8'd0,  8'd0, 8'd0, 4'd0, 4'd1, 4'd0, 32'h0,    32'h0},    // R8 zero block
    '{2'b11, 2'b10, 2'd0, 2'd0, 8'd4,  17'd4,  2'd3, 1'b0, 4'd1, 8'd4,  8'd1, 8'd1, 4'd1, 4'd0, 4'd0, 32'h2003, 32'h0FFD}, // R7
    '{2'b10, 2'b10, 2'd0, 2'd0, 8'd200, 17'd8, 2'd1, 1'b0, 4'd1, 8'd0,  8'd0, 8'd0, 4'd0, 4'd1, 4'd0, 32'h0,    32'h0},    // R8 long buffer
    '{2'b01, 2'b01, 2'd0, 2'd0, 8'd2,  17'd2,  2'd1, 1'b0, 4'd1, 8'd2,  8'd1, 8'd1, 4'd0, 4'd0, 4'd0, 32'h2000, 32'h1000}  // R1 code 01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_en = 1'b0;
  logic [1:0] src_mode = '0, dst_mode = '0, src_size = '0, dst_size = '0, trig = '0;
  logic [7:0] buf_len = 8'd1;
  logic [16:0] blk_len = 17'd1;
  logic ack_en = 1'b0;
  logic preq = 1'b0;
  logic mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr;
  logic [1:0] mem_size, mem_prio;
  logic [63:0] mem_wdata, mem_rdata;
  logic busy, buf_done, blk_done, lst_end, cfg_err;
  logic [3:0] lfsr;

  always #5 clk = ~clk;

  function automatic logic [63:0] pattern(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, a};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 4'h9;
    else        lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
  end
  assign mem_gnt   = mem_req && !lfsr[0];
  assign mem_rdata = pattern(mem_addr);

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en),
    .cfg_src_mode(src_mode), .cfg_dst_mode(dst_mode),
    .cfg_src_size(src_size), .cfg_dst_size(dst_size),
    .cfg_buf_len(buf_len), .cfg_blk_len(blk_len), .cfg_trig(trig), .cfg_prio(PRIO),
    .cfg_src_base(SRC_B), .cfg_dst_base(DST_B),
    .cfg_ack_en(ack_en), .cfg_ack_addr(ACK_A), .cfg_ack_data(32'h0000_00A5),
    .periph_req(preq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_prio(mem_prio), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .busy(busy), .buf_done(buf_done), .blk_done(blk_done), .lst_end(lst_end), .cfg_err(cfg_err)
  );

  // Monitor: cumulative counts, sampled away from the active edge
  int n_wr = 0, n_buf = 0, n_blk = 0, n_lst = 0, n_err = 0, n_ack = 0;
  int dat_bad = 0, size_bad = 0, prio_bad = 0, ack_bad = 0;
  logic [31:0] rd_addr = '0, last_dst = '0, last_src = '0;

  always @(negedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_prio != PRIO) prio_bad++;
      if (!mem_we) rd_addr = mem_addr;
      else if (mem_addr == ACK_A) begin
        n_ack++;
        if (mem_wdata != 64'hA5 || mem_size != 2'd2) ack_bad++;
      end else begin
        n_wr++;
        last_dst = mem_addr;
        last_src = rd_addr;
        if (mem_wdata != pattern(rd_addr)) dat_bad++;
        if (mem_size != src_size) size_bad++;
      end
    end
    if (buf_done) n_buf++;
    if (blk_done) n_blk++;
    if (lst_end)  n_lst++;
    if (cfg_err)  n_err++;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); preq = 1'b1;
    @(negedge clk); preq = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk("watchdog idle wait", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0, b0, k0, l0, e0, a0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13 mem_req in reset", mem_req, 0);
    chk("R13 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 done pulses after reset", buf_done | blk_done | cfg_err, 0);

    // R13: disabled channel ignores requests
    src_mode = 2'b10; dst_mode = 2'b10; buf_len = 8'd4; blk_len = 17'd4; trig = 2'd1;
    w0 = n_wr;
    pulse_req();
    repeat (20) @(negedge clk);
    chk("R13 no beats while disabled", n_wr - w0, 0);
    chk("R13 busy while disabled", busy, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ch_en = 1'b0;
      src_mode = VECS[v].sm; dst_mode = VECS[v].dm;
      src_size = VECS[v].ss; dst_size = VECS[v].ds;
      buf_len = VECS[v].bl; blk_len = VECS[v].kl;
      trig = VECS[v].tm; ack_en = VECS[v].ae;
      repeat (2) @(negedge clk);
      ch_en = 1'b1;
      w0 = n_wr; b0 = n_buf; k0 = n_blk; l0 = n_lst; e0 = n_err; a0 = n_ack;
      for (int r = 0; r < int'(VECS[v].nr); r++) begin
        pulse_req();
        wait_idle();
      end
      $display("vector %0d", v);
      chk("R3 data write count", n_wr - w0, VECS[v].ew);
      chk("R4/R5 buf_done count", n_buf - b0, VECS[v].eb);
      chk("R5/R6 blk_done count", n_blk - k0, VECS[v].ek);
      chk("R7 lst_end count", n_lst - l0, VECS[v].el);
      chk("R8/R9 cfg_err count", n_err - e0, VECS[v].ee);
      chk("R10 ack write count", n_ack - a0, VECS[v].ea);
      if (VECS[v].ew != 0) begin
        chk("R1/R2 last destination address", last_dst, VECS[v].ed);
        chk("R1/R2 last source address", last_src, VECS[v].es);
      end
    end

    // R11: a burst of requests during a unit collapses into one more unit
    @(negedge clk);
    ch_en = 1'b0;
    src_mode = 2'b10; dst_mode = 2'b10; src_size = 2'd0; dst_size = 2'd0;
    buf_len = 8'd8; blk_len = 17'd64; trig = 2'd0; ack_en = 1'b0;
    repeat (2) @(negedge clk);
    ch_en = 1'b1;
    w0 = n_wr; b0 = n_buf;
    @(negedge clk); preq = 1'b1;
    repeat (3) @(negedge clk);
    preq = 1'b0;
    repeat (6) @(negedge clk);
    preq = 1'b1;
    @(negedge clk); preq = 1'b0;
    wait_idle();
    chk("R11 writes for merged requests", n_wr - w0, 16);
    chk("R11 buffers for merged requests", n_buf - b0, 2);
    chk("R4 pointer carried across requests", last_dst, 32'h200F);

    // Global consistency
    chk("R3 write data equals data read", dat_bad, 0);
    chk("R2 beat size code", size_bad, 0);
    chk("R12 priority on every beat", prio_bad, 0);
    chk("R10 ack value and size", ack_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule